// File: doc/BRIEF.md
# I2C Slave Address Match and Receive Controller

This block is the receive side of an I2C slave. It oversamples the SCL and SDA bus lines with the system clock and finds START, repeated START and STOP conditions. It shifts each incoming byte in MSB first and decides on the falling edge of the 8th SCL pulse whether the byte belongs to this slave. A byte that is accepted is copied into a holding buffer and acknowledged. Every byte the slave takes raises an interrupt flag on the falling edge of the 9th SCL pulse.

The buffer-full and overflow status decide whether a byte is stored and acknowledged, so a slow host loses no data without knowing it. In 10-bit mode the host answers each address byte by rewriting the single address register. Until that write happens, the block holds SCL low, so the next address half can be loaded while the bus waits. The host side has one address write port, a buffer read strobe, and clear strobes for the flag and for the overflow bit.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, buf_full, overflow, irq_flag, upd_addr, rw_bit, sda_oe and scl_oe are all 0.
- R2: START is SDA falling while SCL is high, and it begins an address byte. STOP is SDA rising while SCL is high, and it returns the block to idle. In idle, clocked bytes give no ACK and no flag.
- R3: In 7-bit mode, received byte bits [7:1] are compared with address register bits [7:1] at the 8th SCL falling edge. If they match while buf_full=0 and overflow=0, the whole byte goes to rx_buf, buf_full is set, and sda_oe is high from the 8th to the 9th SCL falling edge.
- R4: A first byte that does not match gives no ACK and no flag. Every byte after it is ignored until the next START.
- R5: irq_flag is set at the 9th SCL falling edge of every byte the slave takes: a matching address byte, or a data byte in an addressed write. It stays set until flag_clr.
- R6: A taken byte that arrives with buf_full=1 and overflow=0 is not stored and not acknowledged. It sets overflow and irq_flag.
- R7: A taken byte that arrives with overflow=1 is not stored and not acknowledged, but it still sets irq_flag. overflow clears only on ov_clr.
- R8: buf_rd clears buf_full. rx_buf holds the last stored byte.
- R9: rw_bit takes bit 0 of a matching address byte. After a matching read address, the bytes that follow are not received.
- R10: In 10-bit mode the first byte must have bits [7:3]=11110, and its bits [7:1] must equal address register bits [7:1]. The second, low address byte is compared on all 8 bits.
- R11: In 10-bit mode, each accepted write address byte sets upd_addr at the 9th SCL falling edge. scl_oe stays high while upd_addr is set. A write of the address register clears both. Data bytes do not set upd_addr.
- R12: In 10-bit mode, a high byte with R/W=1 is acknowledged only if the low address byte matched earlier in the same transaction, with no STOP in between. It does not set upd_addr.
- R13: Once the address has fully matched in a write, each later data byte is received with the same buf_full and overflow gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| addr_we | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address register write data |
| buf_rd | input | 1 | Buffer read strobe, clears buf_full |
| flag_clr | input | 1 | Clears irq_flag |
| ov_clr | input | 1 | Clears overflow |
| rx_buf | output | 8 | Holding buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | A byte was refused because the buffer was full |
| irq_flag | output | 1 | Byte-received interrupt flag |
| upd_addr | output | 1 | Address register must be rewritten (10-bit mode) |
| rw_bit | output | 1 | R/W bit of the last matching address byte |

## Verification
The bench builds the block with SYNC_STAGES set to 3, one stage deeper than the default. This checks that START, STOP and the ACK window stay correct when the synchronizer latency grows, since the bus edges that SCL and SDA carry are spaced only a few clocks beyond that latency. Bus timing with six and twelve clocks per phase brings within reach the ACK window, refused bytes with buffer-full and overflow set, the two-step 10-bit address reload with SCL held low, and a repeated-START read.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [4:0] TENBIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FIRST,
    PH_LOW,
    PH_DATA,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic load;
    logic ovf;
    logic flag;
    logic upd;
    logic rw_we;
    logic rw_val;
  } rx_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Idle bus is high: reset to 1 so no edge appears on release.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ten_bit_i,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              bf_i,
  input  logic              ov_i,
  output logic              sda_oe_o,
  output rx_evt_t           evt_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  phase_e            phase_q, next_c;
  logic [BYTE_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sda_oe_q, take_q, upd_q, tenb_q;

  logic start_c, stop_c, dec_c, ack_end_c;
  logic hi_tag_c, match_hi_c, hit_c, upd_c, rwhit_c, low_c, accept_c;

  assign start_c   = sda_fall_i & scl_lvl_i;
  assign stop_c    = sda_rise_i & scl_lvl_i;
  assign dec_c     = scl_fall_i & (cnt_q == LAST_BIT);
  assign ack_end_c = scl_fall_i & (cnt_q == ACK_BIT);

  assign hi_tag_c   = (sr_q[BYTE_W-1 -: 5] == TENBIT_TAG);
  assign match_hi_c = (sr_q[BYTE_W-1:1] == addr_i[BYTE_W-1:1]);

  // Ownership decision for the byte just shifted in.
  always_comb begin
    hit_c   = 1'b0;
    upd_c   = 1'b0;
    rwhit_c = 1'b0;
    low_c   = 1'b0;
    next_c  = PH_SKIP;
    unique case (phase_q)
      PH_FIRST: begin
        if (!ten_bit_i) begin
          hit_c   = match_hi_c;
          rwhit_c = match_hi_c;
          next_c  = (match_hi_c && !sr_q[0]) ? PH_DATA : PH_SKIP;
        end else begin
          hit_c   = hi_tag_c && match_hi_c && (!sr_q[0] || tenb_q);
          rwhit_c = hit_c;
          upd_c   = hit_c && !sr_q[0];
          next_c  = (hit_c && !sr_q[0]) ? PH_LOW : PH_SKIP;
        end
      end
      PH_LOW: begin
        hit_c  = (sr_q == addr_i);
        upd_c  = hit_c;
        low_c  = hit_c;
        next_c = hit_c ? PH_DATA : PH_SKIP;
      end
      PH_DATA: begin
        hit_c  = 1'b1;
        next_c = PH_DATA;
      end
      default: begin
        next_c = PH_SKIP;
      end
    endcase
  end

  assign accept_c = hit_c & ~bf_i & ~ov_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      sr_q     <= '0;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
      take_q   <= 1'b0;
      upd_q    <= 1'b0;
      tenb_q   <= 1'b0;
    end else if (start_c) begin
      phase_q  <= PH_FIRST;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
      take_q   <= 1'b0;
      upd_q    <= 1'b0;
    end else if (stop_c) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
      take_q   <= 1'b0;
      upd_q    <= 1'b0;
      tenb_q   <= 1'b0;
    end else begin
      if (scl_rise_i && phase_q != PH_IDLE) begin
        if (cnt_q < LAST_BIT) begin
          sr_q  <= {sr_q[BYTE_W-2:0], sda_lvl_i};
          cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q == LAST_BIT) begin
          cnt_q <= ACK_BIT;
        end
      end
      if (dec_c) begin
        phase_q  <= next_c;
        sda_oe_q <= accept_c;
        take_q   <= hit_c;
        upd_q    <= upd_c & accept_c;
        if (low_c) tenb_q <= 1'b1;
      end
      if (ack_end_c) begin
        sda_oe_q <= 1'b0;
        take_q   <= 1'b0;
        upd_q    <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end

  assign sda_oe_o     = sda_oe_q;
  assign byte_o       = sr_q;
  assign evt_o.load   = dec_c & accept_c;
  assign evt_o.ovf    = dec_c & hit_c & bf_i & ~ov_i;
  assign evt_o.rw_we  = dec_c & rwhit_c;
  assign evt_o.rw_val = sr_q[0];
  assign evt_o.flag   = ack_end_c & take_q;
  assign evt_o.upd    = ack_end_c & upd_q;
endmodule

// File: rtl/i2c_status_regs.sv
module i2c_status_regs
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  rx_evt_t           evt_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              addr_we_i,
  input  logic [BYTE_W-1:0] addr_wdata_i,
  input  logic              buf_rd_i,
  input  logic              flag_clr_i,
  input  logic              ov_clr_i,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] buf_o,
  output logic              bf_o,
  output logic              ov_o,
  output logic              flag_o,
  output logic              ua_o,
  output logic              rw_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      buf_o  <= '0;
      bf_o   <= 1'b0;
      ov_o   <= 1'b0;
      flag_o <= 1'b0;
      ua_o   <= 1'b0;
      rw_o   <= 1'b0;
    end else begin
      if (addr_we_i) addr_o <= addr_wdata_i;
      if (evt_i.load) buf_o <= byte_i;

      if (evt_i.load)    bf_o <= 1'b1;
      else if (buf_rd_i) bf_o <= 1'b0;

      if (evt_i.ovf)     ov_o <= 1'b1;
      else if (ov_clr_i) ov_o <= 1'b0;

      if (evt_i.flag)      flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;

      // SCL is held low while set, so no new set can meet a write.
      if (addr_we_i)      ua_o <= 1'b0;
      else if (evt_i.upd) ua_o <= 1'b1;

      if (evt_i.rw_we) rw_o <= evt_i.rw_val;
    end
  end
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ten_bit_mode,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_we,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              flag_clr,
  input  logic              ov_clr,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              buf_full,
  output logic              overflow,
  output logic              irq_flag,
  output logic              upd_addr,
  output logic              rw_bit
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic [BYTE_W-1:0] addr_q, shift_byte;
  rx_evt_t evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_bit_engine u_engine (
    .clk(clk), .rst(rst), .ten_bit_i(ten_bit_mode),
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .addr_i(addr_q), .bf_i(buf_full), .ov_i(overflow),
    .sda_oe_o(sda_oe), .evt_o(evt), .byte_o(shift_byte)
  );

  i2c_status_regs u_status (
    .clk(clk), .rst(rst), .evt_i(evt), .byte_i(shift_byte),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wdata),
    .buf_rd_i(buf_rd), .flag_clr_i(flag_clr), .ov_clr_i(ov_clr),
    .addr_o(addr_q), .buf_o(rx_buf), .bf_o(buf_full), .ov_o(overflow),
    .flag_o(irq_flag), .ua_o(upd_addr), .rw_o(rw_bit)
  );

  assign scl_oe = upd_addr;
endmodule

// File: rtl/i2c_addr_rx_chk.sv
module i2c_addr_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       addr_we,
  input logic       buf_rd,
  input logic       flag_clr,
  input logic       ov_clr,
  input logic [7:0] rx_buf,
  input logic       buf_full,
  input logic       overflow,
  input logic       irq_flag,
  input logic       upd_addr,
  input logic       rw_bit
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!buf_full && !overflow && !irq_flag && !upd_addr && !rw_bit && !sda_oe && !scl_oe));

  a_r3_ack_needs_room: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> ($past(!buf_full) && $past(!overflow)));

  a_r3_load_with_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> sda_oe);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  a_r6_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(buf_full));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ov_clr) |=> overflow);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (buf_rd && buf_full) |=> !buf_full);

  a_r8_buf_stable: assert property (@(posedge clk) disable iff (rst)
    !$rose(buf_full) |-> $stable(rx_buf));

  a_r11_hold_until_write: assert property (@(posedge clk) disable iff (rst)
    (upd_addr && !addr_we) |=> upd_addr);

  a_r11_write_releases: assert property (@(posedge clk) disable iff (rst)
    (upd_addr && addr_we) |=> (!upd_addr && !scl_oe));
endmodule

bind i2c_addr_rx i2c_addr_rx_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .addr_we(addr_we), .buf_rd(buf_rd), .flag_clr(flag_clr), .ov_clr(ov_clr),
  .rx_buf(rx_buf), .buf_full(buf_full), .overflow(overflow),
  .irq_flag(irq_flag), .upd_addr(upd_addr), .rw_bit(rw_bit)
);

// File: tb/tb_i2c_addr_rx.sv
module tb_i2c_addr_rx;
  localparam int Q = 6;
  localparam int H = 12;
  localparam int WDOG = 150000;
  localparam int NVEC = 6;
  // {address register, byte sent, expected ACK}
  localparam logic [16:0] VECS [0:NVEC-1] = '{
    {8'hA4, 8'hA4, 1'b1},
    {8'hA4, 8'hA5, 1'b1},
    {8'hA4, 8'hA6, 1'b0},
    {8'h02, 8'h03, 1'b1},
    {8'hFE, 8'h7E, 1'b0},
    {8'h00, 8'h00, 1'b1}
  };

  logic clk = 0, rst = 1, ten = 0;
  logic scl_drv = 1, sda_drv = 1;
  logic addr_we = 0, buf_rd = 0, flag_clr = 0, ov_clr = 0;
  logic [7:0] addr_wdata = '0;
  logic scl_oe, sda_oe, buf_full, overflow, irq_flag, upd_addr, rw_bit;
  logic [7:0] rx_buf;
  logic scl_line, sda_line, ack_seen;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign scl_line = scl_drv & ~scl_oe;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_addr_rx #(.SYNC_STAGES(3)) dut (
    .clk(clk), .rst(rst), .ten_bit_mode(ten), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .buf_rd(buf_rd), .flag_clr(flag_clr), .ov_clr(ov_clr), .rx_buf(rx_buf),
    .buf_full(buf_full), .overflow(overflow), .irq_flag(irq_flag),
    .upd_addr(upd_addr), .rw_bit(rw_bit)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1; scl_drv = 1; wt(H);
    sda_drv = 0; wt(H);
    scl_drv = 0; wt(Q);
  endtask

  task automatic bus_stop();
    scl_drv = 0; wt(Q);
    sda_drv = 0; wt(Q);
    scl_drv = 1; wt(H);
    sda_drv = 1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    scl_drv = 0; wt(Q);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wt(Q);
      scl_drv = 1; wt(H);
      scl_drv = 0; wt(Q);
    end
    sda_drv = 1; wt(Q);
    ack_seen = sda_oe;
    scl_drv = 1; wt(H);
    scl_drv = 0; wt(H);
  endtask

  task automatic wr_addr(input logic [7:0] v);
    addr_wdata = v; addr_we = 1; wt(1); addr_we = 0; wt(2);
  endtask

  task automatic host_ack();
    buf_rd = 1; flag_clr = 1; wt(1); buf_rd = 0; flag_clr = 0; wt(2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wt(5); rst = 0; wt(3);
    // R1 reset state
    chk("R1 buf_full", buf_full, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 upd_addr", upd_addr, 0);
    chk("R1 oe", {sda_oe, scl_oe, rw_bit}, 0);

    // R3 R4 R5 R9: 7-bit address vectors
    for (int v = 0; v < NVEC; v++) begin
      wr_addr(VECS[v][16:9]);
      bus_start();
      send_byte(VECS[v][8:1]);
      chk("R3 R4 ack", ack_seen, VECS[v][0]);
      chk("R5 flag", irq_flag, VECS[v][0]);
      chk("R3 buf_full", buf_full, VECS[v][0]);
      if (VECS[v][0]) begin
        chk("R3 rx_buf", rx_buf, VECS[v][8:1]);
        chk("R9 rw_bit", rw_bit, VECS[v][1]);
      end
      bus_stop();
      host_ack();
    end

    // R13 R6 R7: data bytes in an addressed write
    wr_addr(8'h60);
    bus_start();
    send_byte(8'h60);
    chk("R3 addr ack", ack_seen, 1);
    host_ack();
    send_byte(8'h3C);
    chk("R13 data ack", ack_seen, 1);
    chk("R13 data buf", rx_buf, 8'h3C);
    chk("R13 flag", irq_flag, 1);
    flag_clr = 1; wt(1); flag_clr = 0; wt(2);
    send_byte(8'h5A);
    chk("R6 nack", ack_seen, 0);
    chk("R6 overflow", overflow, 1);
    chk("R6 flag", irq_flag, 1);
    chk("R6 buf kept", rx_buf, 8'h3C);
    host_ack();
    chk("R8 read clears", buf_full, 0);
    send_byte(8'h11);
    chk("R7 nack", ack_seen, 0);
    chk("R7 flag", irq_flag, 1);
    chk("R7 no load", {buf_full, rx_buf}, {1'b0, 8'h3C});
    chk("R7 overflow kept", overflow, 1);
    ov_clr = 1; flag_clr = 1; wt(1); ov_clr = 0; flag_clr = 0; wt(2);
    chk("R7 ov_clr", overflow, 0);
    send_byte(8'h22);
    chk("R13 ack after clear", ack_seen, 1);
    chk("R13 buf", rx_buf, 8'h22);
    bus_stop();
    host_ack();

    // R2: after STOP, bytes are ignored
    send_byte(8'h60);
    chk("R2 idle nack", ack_seen, 0);
    chk("R2 idle flag", irq_flag, 0);

    // R4: mismatch, then matching pattern still ignored
    bus_start();
    send_byte(8'h62);
    chk("R4 nack", ack_seen, 0);
    send_byte(8'h60);
    chk("R4 later ignored", {ack_seen, irq_flag}, 0);
    bus_stop();

    // R9: after a matched read, bytes are not received
    bus_start();
    send_byte(8'h61);
    chk("R9 read ack", ack_seen, 1);
    chk("R9 rw", rw_bit, 1);
    host_ack();
    send_byte(8'h12);
    chk("R9 no receive", {ack_seen, irq_flag, buf_full}, 0);
    bus_stop();

    // R10 R11 R12: 10-bit address 0x2B5
    ten = 1;
    wr_addr(8'hF4);
    bus_start();
    send_byte(8'hF4);
    chk("R10 high ack", ack_seen, 1);
    chk("R11 upd set", upd_addr, 1);
    chk("R5 flag 10b", irq_flag, 1);
    wt(20);
    chk("R11 stretch", {scl_oe, scl_line}, 2'b10);
    host_ack();
    wr_addr(8'hB5);
    chk("R11 release", {upd_addr, scl_oe}, 0);
    send_byte(8'hB5);
    chk("R10 low ack", ack_seen, 1);
    chk("R11 upd low", upd_addr, 1);
    chk("R10 low buf", rx_buf, 8'hB5);
    host_ack();
    wr_addr(8'hF4);
    chk("R11 release 2", scl_oe, 0);
    send_byte(8'h77);
    chk("R13 10b data", {ack_seen, rx_buf}, {1'b1, 8'h77});
    chk("R11 no upd data", upd_addr, 0);
    host_ack();
    bus_start();
    send_byte(8'hF5);
    chk("R12 read ack", ack_seen, 1);
    chk("R12 rw", rw_bit, 1);
    chk("R12 no upd", upd_addr, 0);
    bus_stop();
    host_ack();

    // R12: read high byte without prior low match
    bus_start();
    send_byte(8'hF5);
    chk("R12 read refused", {ack_seen, irq_flag}, 0);
    bus_stop();

    // R10: low byte compared on all 8 bits
    bus_start();
    send_byte(8'hF4);
    chk("R10 high ack again", ack_seen, 1);
    host_ack();
    wr_addr(8'hB5);
    send_byte(8'hB4);
    chk("R10 low mismatch", {ack_seen, irq_flag, upd_addr}, 0);
    bus_stop();

    // R10: first byte without the 11110 tag
    wr_addr(8'h74);
    bus_start();
    send_byte(8'h74);
    chk("R10 no tag", ack_seen, 0);
    bus_stop();
    ten = 0;
    bus_start();
    send_byte(8'h74);
    chk("R3 same byte in 7-bit", ack_seen, 1);
    bus_stop();
    host_ack();

    finish_run();
  end
endmodule